// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive side of a DMA engine for an Ethernet controller. Frame bytes arrive as a stream with start and end markers. The engine stores them into memory buffers of a fixed 128 bytes, and each buffer is described by a two-word descriptor. Software builds a ring of descriptors starting at a base pointer. For each descriptor it writes a buffer address word, whose low two bits hold flags, and a control/status word.

For each buffer the engine first reads the descriptor's address word and checks who owns it. It then packs the incoming bytes into 32-bit words and writes them into the buffer. When the buffer is done, it writes the status word and then sets the ownership bit in the address word. A frame longer than one buffer continues into the descriptors that follow. A descriptor carrying the wrap flag sends the engine back to the ring base. Address filter results arrive as sideband inputs and are recorded in the status of the frame's last descriptor.

If the engine reaches a descriptor that software still owns, it discards the rest of the frame and raises a one-cycle overrun pulse. While the enable input is low, the engine is idle and its descriptor pointer follows the ring base.

Top module: `rx_ring_writer`

## Requirements
- R1: When a start-marked byte arrives while idle, the engine first reads the descriptor's address word at the current pointer and accepts no byte before that read completes. In that word, bit 0 is the used flag and bit 1 is the wrap flag.
- R2: Into a free descriptor, bytes are written little-endian as 32-bit words at (address word with bits 1:0 cleared) plus the byte offset, with at most 128 bytes per buffer. Unused bytes of a frame's final word are zero.
- R3: Once a buffer is done, the status word is written at pointer+4. Then the address word is rewritten with bit 0 set and its other bits unchanged.
- R4: A frame longer than 128 bytes continues in the descriptor at pointer+8, unless R8 applies.
- R5: Status bit 14 is set only in the descriptor holding a frame's first bytes, and bit 15 only in the one holding its last bytes.
- R6: In the last descriptor, status bits 11:0 hold the total frame length in bytes. In every other descriptor these bits are zero.
- R7: The last descriptor's status carries the sideband flags sampled with the end byte: bit 31 for broadcast, bits 26, 25, 24, 23 for address matches 1, 2, 3, 4 (match[0] to match[3]), and bit 22 for a type match. In other descriptors these bits are zero.
- R8: After a descriptor with the wrap flag is used, the next descriptor is the one at the ring base.
- R9: A descriptor whose used flag is 1 receives no write. The engine pulses `rx_overrun` for one cycle, discards the rest of the frame, and keeps its pointer on that descriptor.
- R10: While `rx_en` is low, the engine makes no memory access, accepts and discards every byte, and sets its pointer to the ring base.
- R11: Bytes arriving while idle without a start marker are discarded and cause no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable |
| ring_base | input | 32 | Byte address of the first descriptor |
| in_valid | input | 1 | Byte present on the stream |
| in_data | input | 8 | Stream byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Byte is taken this cycle |
| flag_bcast | input | 1 | Broadcast destination, sampled with the end byte |
| flag_match | input | 4 | Specific-address matches 1 to 4, sampled with the end byte |
| flag_type | input | 1 | Type-ID match, sampled with the end byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Access completes this cycle; read data is valid |
| mem_rdata | input | 32 | Read data |
| rx_overrun | output | 1 | One-cycle pulse when a frame is cut short by an owned descriptor |

## Verification
With a single-cycle memory, the descriptor read is issued one cycle after a start byte is presented, and that byte is taken the cycle after the read. A data word is written in the cycle after its fourth byte, or after its end byte. The status and address write-backs follow in the next two cycles. The overrun pulse appears one cycle after the read that found the descriptor owned. The bench drives bytes on falling edges and holds each byte until `in_ready` is seen high. After each frame it waits well past the three write-back cycles before it reads the descriptors and buffers from its memory model. The one check that depends on an exact cycle is the check on the fetch address: it samples on the falling edge one cycle after the start byte.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

  localparam int unsigned LEN_W = 12;
  localparam logic [31:0] DESC_STEP = 32'd8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_FILL, ST_WDATA, ST_WSTAT, ST_WADDR, ST_DROP
  } rxw_state_e;

  function automatic logic [31:0] compose_status(
      input logic first, input logic last, input logic [LEN_W-1:0] len,
      input logic bcast, input logic [3:0] match, input logic type_hit);
    logic [31:0] s;
    s = '0;
    s[14] = first;
    if (last) begin
      s[15]      = 1'b1;
      s[LEN_W-1:0] = len;
      s[31]      = bcast;
      s[26]      = match[0];
      s[25]      = match[1];
      s[24]      = match[2];
      s[23]      = match[3];
      s[22]      = type_hit;
    end
    return s;
  endfunction

  function automatic logic [31:0] buf_word_addr(input logic [31:0] addr_word,
                                                input logic [31:0] offset);
    return {addr_word[31:2], 2'b00} + offset;
  endfunction

  function automatic logic [31:0] step_ptr(input logic [31:0] ptr,
                                           input logic [31:0] base,
                                           input logic wrap);
    return wrap ? base : ptr + DESC_STEP;
  endfunction

endpackage

// File: rtl/rxw_packer.sv
module rxw_packer
  import rxw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_clr,
  input  logic             word_clr,
  input  logic             take,
  input  logic [7:0]       byte_in,
  output logic [31:0]      word_q,
  output logic [2:0]       nbytes_q,
  output logic [LEN_W-1:0] len_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || frame_clr) begin
      word_q   <= '0;
      nbytes_q <= '0;
      len_q    <= '0;
    end else if (word_clr) begin
      word_q   <= '0;
      nbytes_q <= '0;
    end else if (take) begin
      word_q[{nbytes_q[1:0], 3'b000} +: 8] <= byte_in;
      nbytes_q <= nbytes_q + 3'd1;
      len_q    <= len_q + 1'b1;
    end
  end
endmodule

// File: rtl/rxw_desc_ptr.sv
module rxw_desc_ptr
  import rxw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] base,
  input  logic        step,
  input  logic        wrap,
  output logic [31:0] ptr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    ptr_q <= '0;
    else if (load) ptr_q <= base;
    else if (step) ptr_q <= step_ptr(ptr_q, base, wrap);
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxw_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_en,
  input  logic [31:0] ring_base,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_eof,
  output logic        in_ready,
  input  logic        flag_bcast,
  input  logic [3:0]  flag_match,
  input  logic        flag_type,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ready,
  input  logic [31:0] mem_rdata,
  output logic        rx_overrun
);
  localparam int unsigned OFF_W = $clog2(BUF_BYTES) + 1;
  localparam logic [OFF_W-1:0] OFF_END  = OFF_W'(BUF_BYTES);
  localparam logic [OFF_W-1:0] OFF_WORD = OFF_W'(4);

  rxw_state_e st_q, st_d;
  logic [31:0]      desc_q, ptr;
  logic [OFF_W-1:0] off_q;
  logic             first_q, eof_q, bc_q, ty_q, ovr_q;
  logic [3:0]       match_q;
  logic [31:0]      word;
  logic [2:0]       nbytes;
  logic [LEN_W-1:0] flen;

  // named internal events (used by the checker)
  logic ev_fetch, ev_fetch_owned, ev_fetch_free;
  logic ev_buf_wr, ev_stat_wr, ev_addr_wr;
  logic take, word_done, frame_clr, ptr_step, buf_full;

  assign ev_fetch       = rx_en && (st_q == ST_FETCH);
  assign ev_fetch_owned = ev_fetch && mem_ready && mem_rdata[0];
  assign ev_fetch_free  = ev_fetch && mem_ready && !mem_rdata[0];
  assign ev_buf_wr      = rx_en && (st_q == ST_WDATA);
  assign ev_stat_wr     = rx_en && (st_q == ST_WSTAT);
  assign ev_addr_wr     = rx_en && (st_q == ST_WADDR);
  assign take           = rx_en && (st_q == ST_FILL) && in_valid;
  assign word_done      = ev_buf_wr && mem_ready;
  assign ptr_step       = ev_addr_wr && mem_ready;
  assign frame_clr      = !rx_en || (st_q == ST_IDLE);
  assign buf_full       = (off_q + OFF_WORD) == OFF_END;
  assign rx_overrun     = ovr_q;

  rxw_packer u_packer (
    .clk(clk), .rst_n(rst_n), .frame_clr(frame_clr), .word_clr(word_done),
    .take(take), .byte_in(in_data), .word_q(word), .nbytes_q(nbytes), .len_q(flen)
  );

  rxw_desc_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .load(!rx_en), .base(ring_base),
    .step(ptr_step), .wrap(desc_q[1]), .ptr_q(ptr)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr;
    mem_wdata = '0;
    in_ready  = 1'b0;
    st_d      = st_q;
    if (!rx_en) begin
      in_ready = 1'b1;
      st_d     = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: begin
          in_ready = !(in_valid && in_sof);
          if (in_valid && in_sof) st_d = ST_FETCH;
        end
        ST_FETCH: begin
          mem_req = 1'b1;
          if (mem_ready) st_d = mem_rdata[0] ? ST_DROP : ST_FILL;
        end
        ST_FILL: begin
          in_ready = 1'b1;
          if (take && (in_eof || nbytes == 3'd3)) st_d = ST_WDATA;
        end
        ST_WDATA: begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = buf_word_addr(desc_q, 32'(off_q));
          mem_wdata = word;
          if (mem_ready) st_d = (eof_q || buf_full) ? ST_WSTAT : ST_FILL;
        end
        ST_WSTAT: begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = ptr + 32'd4;
          mem_wdata = compose_status(first_q, eof_q, flen, bc_q, match_q, ty_q);
          if (mem_ready) st_d = ST_WADDR;
        end
        ST_WADDR: begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_wdata = desc_q | 32'h1;
          if (mem_ready) st_d = eof_q ? ST_IDLE : ST_FETCH;
        end
        ST_DROP: begin
          in_ready = 1'b1;
          if (in_valid && in_eof) st_d = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      desc_q  <= '0;
      off_q   <= '0;
      first_q <= 1'b0;
      eof_q   <= 1'b0;
      bc_q    <= 1'b0;
      ty_q    <= 1'b0;
      match_q <= '0;
      ovr_q   <= 1'b0;
    end else begin
      st_q  <= st_d;
      ovr_q <= ev_fetch_owned;
      if (rx_en && st_q == ST_IDLE && in_valid && in_sof) begin
        first_q <= 1'b1;
        eof_q   <= 1'b0;
      end
      if (ev_fetch_free) begin
        desc_q <= mem_rdata;
        off_q  <= '0;
      end
      if (word_done) off_q <= off_q + OFF_WORD;
      if (take && in_eof) begin
        eof_q   <= 1'b1;
        bc_q    <= flag_bcast;
        match_q <= flag_match;
        ty_q    <= flag_type;
      end
      if (ptr_step) first_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rxw_checker.sv
module rxw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_en,
  input logic        in_ready,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        rx_overrun,
  input logic        ev_buf_wr,
  input logic        ev_stat_wr,
  input logic        ev_addr_wr
);
  AST_FETCH_HOLDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> !in_ready);                                      // R1
  AST_BUF_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_buf_wr |-> (mem_we && mem_addr[1:0] == 2'b00));                        // R2
  AST_USED_SET_ON_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_wr |-> mem_wdata[0]);                                             // R3
  AST_STATUS_BEFORE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_addr_wr) |-> $past(ev_stat_wr));                                 // R3
  AST_LEN_ONLY_IN_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stat_wr && !mem_wdata[15]) |-> (mem_wdata[11:0] == 12'd0));           // R6
  AST_OVERRUN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |=> !rx_overrun);                                              // R9
  AST_OVERRUN_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> !mem_req);                                                 // R9
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> (!mem_req && in_ready));                                       // R10
endmodule

bind rx_ring_writer rxw_checker u_rxw_checker (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_ready(in_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .rx_overrun(rx_overrun), .ev_buf_wr(ev_buf_wr), .ev_stat_wr(ev_stat_wr),
  .ev_addr_wr(ev_addr_wr)
);

// File: tb/test_rx_ring_writer.sv
module test_rx_ring_writer;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready;
  logic flag_bcast = 1'b0, flag_type = 1'b0;
  logic [3:0] flag_match = '0;
  logic mem_req, mem_we, rx_overrun;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic mem_ready = 1'b1;

  logic [31:0] mem [0:255];
  logic h_we = 1'b0;
  logic [31:0] h_addr = '0, h_data = '0;
  int wr_cnt = 0, ovr_cnt = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    if (h_we) mem[h_addr[9:2]] <= h_data;
    else if (mem_req && mem_we && mem_ready) begin
      mem[mem_addr[9:2]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (rx_overrun) ovr_cnt <= ovr_cnt + 1;
  end

  rx_ring_writer i_rx_ring_writer (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(BASE),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_ready(in_ready), .flag_bcast(flag_bcast), .flag_match(flag_match),
    .flag_type(flag_type), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .rx_overrun(rx_overrun)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed + 8'(i * 5);
  endfunction

  function automatic logic [31:0] desc_addr(input int k);
    return BASE + 32'(k * 8);
  endfunction

  task automatic host_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    h_we = 1'b1; h_addr = a; h_data = d;
    @(negedge clk);
    h_we = 1'b0;
  endtask

  task automatic init_ring();
    for (int k = 0; k < 4; k++) begin
      host_write(desc_addr(k), 32'h200 + 32'(k * 128) + ((k == 3) ? 32'h2 : 32'h0));
      host_write(desc_addr(k) + 4, 32'h0);
    end
  endtask

  task automatic send_frame(input int len, input logic [7:0] seed, input logic bc,
                            input logic [3:0] m, input logic ty, input bit sof_mark,
                            input bit chk_fetch, input logic [31:0] fetch_at);
    @(negedge clk);
    flag_bcast = bc; flag_match = m; flag_type = ty;
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1; in_data = pat(seed, i);
      in_sof = sof_mark && (i == 0); in_eof = (i == len - 1);
      #1;
      if (chk_fetch && i == 0) begin
        check("R1 start byte held while idle", {31'd0, in_ready}, 32'd0);
        @(negedge clk);
        check("R1 descriptor read issued at pointer",
              {mem_req, mem_we, 30'd0} ^ mem_addr, {1'b1, 1'b0, 30'd0} ^ fetch_at);
        #1;
      end
      while (!in_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // one check per buffer: count bytes [first, first+cnt) of the pattern, pad zero
  task automatic check_buf(input string tag, input int k, input logic [7:0] seed,
                           input int first, input int cnt);
    int bad = 0;
    for (int w = 0; w < (cnt + 3) / 4; w++) begin
      logic [31:0] e;
      e = '0;
      for (int b = 0; b < 4; b++)
        if (w * 4 + b < cnt) e[b*8 +: 8] = pat(seed, first + w * 4 + b);
      if (mem[(32'h200 + 32'(k * 128) + 32'(w * 4)) >> 2] !== e) bad++;
    end
    check(tag, 32'(bad), 32'd0);
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem[a[9:2]];
  endfunction

  task automatic t_reset();
    check("R10 reset: ready while disabled", {31'd0, in_ready}, 32'd1);
    check("R10 reset: no memory request", {31'd0, mem_req}, 32'd0);
    check("R9 reset: overrun low", {31'd0, rx_overrun}, 32'd0);
  endtask

  task automatic t_short();
    send_frame(5, 8'h10, 1'b1, 4'b0101, 1'b0, 1, 1, desc_addr(0));
    check("R3 short: used bit set", rd(desc_addr(0)), 32'h201);
    check("R5 R6 R7 short: status", rd(desc_addr(0) + 4), 32'h8500C005);
    check_buf("R2 short: buffer data with zero pad", 0, 8'h10, 0, 5);
  endtask

  task automatic t_span();
    send_frame(200, 8'h33, 1'b0, 4'b1000, 1'b1, 1, 1, desc_addr(1));
    check("R5 R6 R7 span: first descriptor status", rd(desc_addr(1) + 4), 32'h00004000);
    check("R3 span: first descriptor used", rd(desc_addr(1)), 32'h281);
    check("R4 R6 R7 span: last descriptor status", rd(desc_addr(2) + 4), 32'h00C080C8);
    check("R4 span: last descriptor used", rd(desc_addr(2)), 32'h301);
    check_buf("R2 span: first buffer full", 1, 8'h33, 0, 128);
    check_buf("R4 span: second buffer tail", 2, 8'h33, 128, 72);
  endtask

  task automatic t_wrap();
    send_frame(10, 8'h55, 1'b0, 4'b0000, 1'b0, 1, 0, 32'h0);
    check("R3 wrap: used set, wrap kept", rd(desc_addr(3)), 32'h383);
    check("R5 wrap: status", rd(desc_addr(3) + 4), 32'h0000C00A);
    host_write(desc_addr(0), 32'h200);
    host_write(desc_addr(0) + 4, 32'h0);
    send_frame(6, 8'h77, 1'b0, 4'b0000, 1'b1, 1, 1, desc_addr(0));
    check("R8 wrap: next frame at ring base", rd(desc_addr(0) + 4), 32'h0040C006);
    check_buf("R8 wrap: data at base buffer", 0, 8'h77, 0, 6);
  endtask

  task automatic t_exact();
    init_ring();
    send_frame(128, 8'h9A, 1'b0, 4'b0010, 1'b0, 1, 0, 32'h0);
    check("R6 exact 128: single descriptor status", rd(desc_addr(1) + 4), 32'h0200C080);
    check("R4 exact 128: next descriptor untouched", rd(desc_addr(2) + 4), 32'h0);
    check_buf("R2 exact 128: data", 1, 8'h9A, 0, 128);
  endtask

  task automatic t_overrun();
    int o0;
    init_ring();
    host_write(desc_addr(3), 32'h383);
    o0 = ovr_cnt;
    send_frame(150, 8'h21, 1'b0, 4'b0000, 1'b0, 1, 0, 32'h0);
    check("R9 overrun: one pulse", 32'(ovr_cnt - o0), 32'd1);
    check("R9 overrun: owned address word untouched", rd(desc_addr(3)), 32'h383);
    check("R9 overrun: owned status untouched", rd(desc_addr(3) + 4), 32'h0);
    check("R5 overrun: partial first descriptor", rd(desc_addr(2) + 4), 32'h00004000);
    host_write(desc_addr(3), 32'h382);
    send_frame(4, 8'h44, 1'b1, 4'b0000, 1'b0, 1, 1, desc_addr(3));
    check("R9 overrun: pointer stayed on owned descriptor", rd(desc_addr(3) + 4), 32'h8000C004);
  endtask

  task automatic t_disable();
    int w0;
    init_ring();
    send_frame(3, 8'h01, 1'b0, 4'b0000, 1'b0, 1, 0, 32'h0);
    check("R6 before disable: frame at base", rd(desc_addr(0) + 4), 32'h0000C003);
    @(negedge clk); rx_en = 1'b0;
    w0 = wr_cnt;
    send_frame(8, 8'h02, 1'b0, 4'b0000, 1'b0, 1, 0, 32'h0);
    check("R10 disabled: no memory writes", 32'(wr_cnt - w0), 32'd0);
    @(negedge clk); rx_en = 1'b1;
    init_ring();
    send_frame(4, 8'h03, 1'b0, 4'b0000, 1'b0, 1, 1, desc_addr(0));
    check("R10 re-enable: pointer back at base", rd(desc_addr(0) + 4), 32'h0000C004);
  endtask

  task automatic t_stray();
    int w0;
    w0 = wr_cnt;
    send_frame(5, 8'h66, 1'b0, 4'b0000, 1'b0, 0, 0, 32'h0);
    check("R11 stray bytes: no writes", 32'(wr_cnt - w0), 32'd0);
    send_frame(2, 8'h88, 1'b0, 4'b0000, 1'b0, 1, 1, desc_addr(1));
    check("R11 stray bytes: next frame normal", rd(desc_addr(1) + 4), 32'h0000C002);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    init_ring();
    @(negedge clk);
    t_reset();
    rx_en = 1'b1;
    t_short();
    t_span();
    t_wrap();
    t_exact();
    t_overrun();
    t_disable();
    t_stray();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule